// File: doc/BRIEF.md
# ADC Input Enable Qualifier

This block is the front end between two high-speed converter input ports and four downstream processing channels. Each port delivers a 14-bit two's-complement mantissa, a 3-bit unsigned exponent and an enable pin, all captured on the rising edge of the single system clock. A plain fixed-point converter can be attached by holding its exponent at zero.

Each channel picks one of the two ports and one of four enable-qualification modes. It then emits a one-bit valid strobe and a 21-bit fixed-point sample. The sample is the sign-extended mantissa shifted left by the exponent. The edge modes let one interleaved converter stream be split across two channels, one taking the samples marked by each enable transition. This also works when the system clock runs faster than the data rate: only the clock that follows a transition is accepted, and the rest are ignored by the front end.

Top module: `adc_enable_qualifier`

## Requirements
- R1: A synchronous reset (`rst` high) clears every channel: after the first clock edge with `rst` low, `ch_valid` is all zero and every `ch_data` slice is zero.
- R2: `ch_port[c]` selects the source of channel c: 0 takes port A (`a_*`), 1 takes port B (`b_*`). Each channel selects independently of the others.
- R3: Mode 2'b00 (level) on `ch_mode[2c+1:2c]` asserts `ch_valid[c]` for every sample captured while the selected enable pin was high.
- R4: Mode 2'b01 (falling) asserts `ch_valid[c]` for exactly one cycle, carrying the first sample captured with the enable low after a sample captured with it high.
- R5: Mode 2'b10 (rising) asserts `ch_valid[c]` for exactly one cycle, carrying the first sample captured with the enable high after a sample captured with it low.
- R6: Mode 2'b11 (blank) asserts `ch_valid[c]` for every captured sample. The data is forced to zero when that sample's enable was low.
- R7: The sample is sign-extend(mantissa) shifted left by exponent (0 to 7) in a 21-bit two's-complement word. It appears two clock edges after the port inputs are presented: the inputs are captured at edge k and the output is valid after edge k+1.
- R8: Whenever `ch_valid[c]` is low, the `ch_data` slice of channel c is zero.
- R9: Edge detection starts only once two samples have been captured after reset. An enable pin that is already high (or low) when reset releases produces no edge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_mant | input | 14 | Port A mantissa, two's complement |
| a_exp | input | 3 | Port A exponent, unsigned |
| a_en | input | 1 | Port A enable pin |
| b_mant | input | 14 | Port B mantissa, two's complement |
| b_exp | input | 3 | Port B exponent, unsigned |
| b_en | input | 1 | Port B enable pin |
| ch_mode | input | 8 | Two-bit mode per channel, channel c at bits [2c+1:2c] |
| ch_port | input | 4 | Port select per channel, bit c for channel c |
| ch_valid | output | 4 | Accepted-sample strobe per channel |
| ch_data | output | 84 | 21-bit sample per channel, channel c at bits [21c+20:21c] |

## Verification
The bench targets the cycles around reset release with the enable pins already high or low. A design that primes its edge history with a reset value would fire a false rising or falling strobe there. It drives a slow enable toggle, holding each level for several clocks, to emulate a clock faster than the data rate. A design that strobes on the level rather than on the transition would emit repeated valid pulses. The mantissa extremes are swept against all eight exponents, which exposes truncation or a missing sign extension in the shifter. Blank channels are checked for zeroed data with valid still high.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  typedef enum logic [1:0] {
    QM_LEVEL = 2'b00,
    QM_FALL  = 2'b01,
    QM_RISE  = 2'b10,
    QM_BLANK = 2'b11
  } qual_mode_e;

endpackage

// File: rtl/adcq_port_tap.sv
// Captures one converter port and derives its enable transition events.
module adcq_port_tap #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] pin_mant,
  input  logic [EXP_W-1:0]  pin_exp,
  input  logic              pin_en,
  output logic [MANT_W-1:0] mant_q,
  output logic [EXP_W-1:0]  exp_q,
  output logic              en_q,
  output logic              cap_ok,
  output logic              rise_evt,
  output logic              fall_evt
);

  logic en_prev;
  logic hist_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mant_q  <= '0;
      exp_q   <= '0;
      en_q    <= 1'b0;
      en_prev <= 1'b0;
      cap_ok  <= 1'b0;
      hist_ok <= 1'b0;
    end else begin
      mant_q  <= pin_mant;
      exp_q   <= pin_exp;
      en_q    <= pin_en;
      en_prev <= en_q;
      cap_ok  <= 1'b1;
      hist_ok <= cap_ok;
    end
  end

  // Transitions count only when both compared levels are real captures.
  assign rise_evt = hist_ok &  en_q & ~en_prev;
  assign fall_evt = hist_ok & ~en_q &  en_prev;

endmodule

// File: rtl/adcq_expand.sv
// Mantissa/exponent to fixed-point expansion.
module adcq_expand #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = MANT_W + (1 << EXP_W) - 1
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  output logic [OUT_W-1:0]  word
);

  localparam int EXT_W = OUT_W - MANT_W;

  function automatic logic [OUT_W-1:0] scale(input logic [MANT_W-1:0] m,
                                             input logic [EXP_W-1:0]  e);
    logic [OUT_W-1:0] ext;
    ext   = {{EXT_W{m[MANT_W-1]}}, m};
    scale = ext << e;
  endfunction

  assign word = scale(mant, expo);

endmodule

// File: rtl/adcq_chan_qual.sv
// One processing channel: port choice, mode qualification, output register.
module adcq_chan_qual
  import adcq_pkg::*;
#(
  parameter int MANT_W    = 14,
  parameter int EXP_W     = 3,
  parameter int NUM_PORTS = 2,
  parameter int SEL_W     = 1,
  parameter int OUT_W     = MANT_W + (1 << EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  sel,
  input  logic [MANT_W-1:0] tap_mant [NUM_PORTS],
  input  logic [EXP_W-1:0]  tap_exp  [NUM_PORTS],
  input  logic              tap_en   [NUM_PORTS],
  input  logic              tap_ok   [NUM_PORTS],
  input  logic              tap_rise [NUM_PORTS],
  input  logic              tap_fall [NUM_PORTS],
  output logic              valid,
  output logic [OUT_W-1:0]  data
);

  qual_mode_e       qmode;
  logic [MANT_W-1:0] s_mant;
  logic [EXP_W-1:0]  s_exp;
  logic              s_en, s_ok, s_rise, s_fall;
  logic              accept;
  logic              blank_zero;
  logic [OUT_W-1:0]  wide;
  logic [OUT_W-1:0]  nxt_data;

  assign qmode  = qual_mode_e'(mode);
  assign s_mant = tap_mant[sel];
  assign s_exp  = tap_exp[sel];
  assign s_en   = tap_en[sel];
  assign s_ok   = tap_ok[sel];
  assign s_rise = tap_rise[sel];
  assign s_fall = tap_fall[sel];

  always_comb begin
    unique case (qmode)
      QM_LEVEL: accept = s_en;
      QM_FALL:  accept = s_fall;
      QM_RISE:  accept = s_rise;
      QM_BLANK: accept = s_ok;
      default:  accept = 1'b0;
    endcase
  end

  assign blank_zero = (qmode == QM_BLANK) && !s_en;

  adcq_expand #(
    .MANT_W(MANT_W),
    .EXP_W (EXP_W),
    .OUT_W (OUT_W)
  ) u_expand (
    .mant(s_mant),
    .expo(s_exp),
    .word(wide)
  );

  assign nxt_data = (accept && !blank_zero) ? wide : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= accept;
      data  <= nxt_data;
    end
  end

endmodule

// File: rtl/adc_enable_qualifier.sv
module adc_enable_qualifier #(
  parameter int MANT_W = 14,
  parameter int EXP_W  = 3,
  parameter int NUM_CH = 4,
  localparam int NUM_PORTS = 2,
  localparam int SEL_W     = 1,
  localparam int OUT_W     = MANT_W + (1 << EXP_W) - 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [MANT_W-1:0]       a_mant,
  input  logic [EXP_W-1:0]        a_exp,
  input  logic                    a_en,
  input  logic [MANT_W-1:0]       b_mant,
  input  logic [EXP_W-1:0]        b_exp,
  input  logic                    b_en,
  input  logic [2*NUM_CH-1:0]     ch_mode,
  input  logic [NUM_CH-1:0]       ch_port,
  output logic [NUM_CH-1:0]       ch_valid,
  output logic [NUM_CH*OUT_W-1:0] ch_data
);

  logic [MANT_W-1:0] pin_mant [NUM_PORTS];
  logic [EXP_W-1:0]  pin_exp  [NUM_PORTS];
  logic              pin_en   [NUM_PORTS];

  logic [MANT_W-1:0] tap_mant [NUM_PORTS];
  logic [EXP_W-1:0]  tap_exp  [NUM_PORTS];
  logic              tap_en   [NUM_PORTS];
  logic              tap_ok   [NUM_PORTS];
  logic              tap_rise [NUM_PORTS];
  logic              tap_fall [NUM_PORTS];

  assign pin_mant[0] = a_mant;
  assign pin_exp[0]  = a_exp;
  assign pin_en[0]   = a_en;
  assign pin_mant[1] = b_mant;
  assign pin_exp[1]  = b_exp;
  assign pin_en[1]   = b_en;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    adcq_port_tap #(
      .MANT_W(MANT_W),
      .EXP_W (EXP_W)
    ) u_tap (
      .clk     (clk),
      .rst     (rst),
      .pin_mant(pin_mant[p]),
      .pin_exp (pin_exp[p]),
      .pin_en  (pin_en[p]),
      .mant_q  (tap_mant[p]),
      .exp_q   (tap_exp[p]),
      .en_q    (tap_en[p]),
      .cap_ok  (tap_ok[p]),
      .rise_evt(tap_rise[p]),
      .fall_evt(tap_fall[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    adcq_chan_qual #(
      .MANT_W   (MANT_W),
      .EXP_W    (EXP_W),
      .NUM_PORTS(NUM_PORTS),
      .SEL_W    (SEL_W),
      .OUT_W    (OUT_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .mode    (ch_mode[2*c +: 2]),
      .sel     (ch_port[c +: SEL_W]),
      .tap_mant(tap_mant),
      .tap_exp (tap_exp),
      .tap_en  (tap_en),
      .tap_ok  (tap_ok),
      .tap_rise(tap_rise),
      .tap_fall(tap_fall),
      .valid   (ch_valid[c]),
      .data    (ch_data[c*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/adcq_checker.sv
module adcq_checker #(
  parameter int NUM_CH = 4,
  parameter int OUT_W  = 21
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    a_en,
  input logic                    b_en,
  input logic [2*NUM_CH-1:0]     ch_mode,
  input logic [NUM_CH-1:0]       ch_port,
  input logic [NUM_CH-1:0]       ch_valid,
  input logic [NUM_CH*OUT_W-1:0] ch_data
);

  // R1: reset clears every strobe on the next edge
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (ch_valid == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R8: idle channels carry zero data
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
      !ch_valid[i] |-> (ch_data[i*OUT_W +: OUT_W] == '0));

    // R3: level mode only accepts samples taken with the enable high
    p_level_high_r3: assert property (@(posedge clk) disable iff (rst)
      (ch_valid[i] && ch_mode[2*i +: 2] == 2'b00)
        |-> (ch_port[i] ? $past(b_en, 2) : $past(a_en, 2)));

    // R4: falling-edge strobe lasts a single cycle
    p_fall_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_valid[i] && ch_mode[2*i +: 2] == 2'b01)
        |=> !(ch_valid[i] && ch_mode[2*i +: 2] == 2'b01));

    // R5: rising-edge strobe lasts a single cycle
    p_rise_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      (ch_valid[i] && ch_mode[2*i +: 2] == 2'b10)
        |=> !(ch_valid[i] && ch_mode[2*i +: 2] == 2'b10));

    // R6: blank mode zeroes samples taken with the enable low
    p_blank_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (ch_valid[i] && ch_mode[2*i +: 2] == 2'b11
        && !(ch_port[i] ? $past(b_en, 2) : $past(a_en, 2)))
        |-> (ch_data[i*OUT_W +: OUT_W] == '0));
  end

endmodule

bind adc_enable_qualifier adcq_checker #(
  .NUM_CH(NUM_CH),
  .OUT_W (OUT_W)
) u_adcq_checker (
  .clk     (clk),
  .rst     (rst),
  .a_en    (a_en),
  .b_en    (b_en),
  .ch_mode (ch_mode),
  .ch_port (ch_port),
  .ch_valid(ch_valid),
  .ch_data (ch_data)
);

// File: tb/tb_adc_enable_qualifier.sv
`timescale 1ns/1ps
module tb_adc_enable_qualifier;

  localparam int NCH   = 4;
  localparam int OW    = 21;
  localparam int NCYC  = 40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [13:0]       a_mant = '0, b_mant = '0;
  logic [2:0]        a_exp = '0, b_exp = '0;
  logic              a_en = 1'b0, b_en = 1'b0;
  logic [2*NCH-1:0]  ch_mode = '0;
  logic [NCH-1:0]    ch_port = '0;
  logic [NCH-1:0]    ch_valid;
  logic [NCH*OW-1:0] ch_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [13:0] h_mant [2][0:NCYC];
  logic [2:0]  h_exp  [2][0:NCYC];
  logic        h_en   [2][0:NCYC];

  always #5 clk = ~clk;

  adc_enable_qualifier dut (
    .clk(clk), .rst(rst),
    .a_mant(a_mant), .a_exp(a_exp), .a_en(a_en),
    .b_mant(b_mant), .b_exp(b_exp), .b_en(b_en),
    .ch_mode(ch_mode), .ch_port(ch_port),
    .ch_valid(ch_valid), .ch_data(ch_data)
  );

  function automatic logic [OW-1:0] ref_word(input logic [13:0] m, input logic [2:0] e);
    int v;
    v = int'(m);
    if (v >= 8192) v = v - 16384;
    v = v * (1 << e);
    return OW'(v);
  endfunction

  task automatic check(input string tag, input int ch, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s ch%0d %s: actual %h expected %h", tag, ch, what, act, exp_v);
    end
  endtask

  // One run: fixed configuration, pins follow a pattern, every cycle checked.
  task automatic run(input int cfg, input int pat);
    for (int c = 0; c < NCH; c++) begin
      ch_mode[2*c +: 2] = 2'((cfg + c) % 4);
      ch_port[c]        = 1'((cfg / 4 + c) % 2);
    end
    for (int n = 0; n <= NCYC; n++) begin
      for (int p = 0; p < 2; p++) begin
        case (n % 5)
          0: h_mant[p][n] = 14'h2000;
          1: h_mant[p][n] = 14'h1FFF;
          default: h_mant[p][n] = 14'($urandom);
        endcase
        h_exp[p][n] = 3'((n + cfg + 3 * p) % 8);
        case (pat)
          0: h_en[p][n] = 1'($urandom);
          1: h_en[p][n] = 1'b1;
          default: h_en[p][n] = 1'(((n + p) / 3) % 2);
        endcase
      end
    end
    @(negedge clk);
    rst = 1'b1;
    a_en = h_en[0][0]; b_en = h_en[1][0];
    @(posedge clk);
    for (int n = 1; n <= NCYC; n++) begin
      @(negedge clk);
      rst    = 1'b0;
      a_mant = h_mant[0][n]; a_exp = h_exp[0][n]; a_en = h_en[0][n];
      b_mant = h_mant[1][n]; b_exp = h_exp[1][n]; b_en = h_en[1][n];
      @(posedge clk);
      #1;
      for (int c = 0; c < NCH; c++) begin
        int p;
        int md;
        logic e1, e2, v;
        logic [OW-1:0] d;
        string tag;
        p  = int'(ch_port[c]);
        md = int'(ch_mode[2*c +: 2]);
        e1 = (n >= 2) ? h_en[p][n-1] : 1'b0;
        e2 = (n >= 3) ? h_en[p][n-2] : 1'b0;
        case (md)
          0: begin v = (n >= 2) && e1;              tag = "R3"; end
          1: begin v = (n >= 3) && !e1 && e2;       tag = "R4"; end
          2: begin v = (n >= 3) && e1 && !e2;       tag = "R5"; end
          default: begin v = (n >= 2);              tag = "R6"; end
        endcase
        if (n == 1) tag = "R1";
        if (pat == 1 && md == 2) tag = "R9";
        if (!v || (md == 3 && !e1)) d = '0;
        else d = ref_word(h_mant[p][n-1], h_exp[p][n-1]);
        check(tag, c, OW'(ch_valid[c]), OW'(v), "valid");
        if (!v) check("R8", c, ch_data[c*OW +: OW], d, "idle data");
        else    check("R2/R7", c, ch_data[c*OW +: OW], d, "data");
      end
    end
  endtask

  initial begin
    for (int pat = 0; pat < 3; pat++)
      for (int cfg = 0; cfg < 8; cfg++)
        run(cfg, pat);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule